// File: doc/BRIEF.md
# Configurable External Interrupt Controller

This block collects a parameterised number of asynchronous external interrupt pins, from 1 to 32. Each pin passes through a synchroniser and then an event detector. The detector can be set, per line, to fire on a rising edge, a falling edge, a high level or a low level. Each detected event sets a sticky status bit. The status bits are gated by a per-line mask, and the result drives one combined interrupt request to the processor. Line 0 can also be routed to a separate non-maskable interrupt output.

Software reaches the block through a simple 32-bit register bus with a write strobe, a read strobe, a byte address and write data. The mask has separate write-one-to-set and write-one-to-clear addresses. Status bits are acknowledged through a write-one-to-clear address. To find how many lines exist, software writes all ones to the sense-mode register and reads the value back.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the mask, status, sense-mode, edge-polarity, level-polarity and NMI-control registers all read 0, and `irq_out` and `nmi_out` are low. All lines therefore start as falling-edge sensitive and masked.
- R2: Writing to byte address 0x00 sets each mask bit whose write-data bit is 1. Writing to 0x04 clears each mask bit whose write-data bit is 1. Write-data bits that are 0 leave the mask unchanged. The current mask reads back at 0x08.
- R3: Status reads at byte address 0x0C. Writing to 0x10 clears each status bit whose write-data bit is 1 and leaves the other status bits unchanged.
- R4: The per-line sense mode is selected as follows. A bit of 1 at 0x14 selects level sensing, and 0 selects edge sensing. For edge sensing, a bit of 1 at 0x18 selects rising and 0 selects falling. For level sensing, a bit of 1 at 0x1C selects active-high and 0 selects active-low. All three registers read back what was written.
- R5: A level-sensitive line sets its status bit on every cycle in which its active level is present. Clearing the bit while that level persists leaves it set.
- R6: When a detected event and a clear write hit the same line in the same cycle, the status bit stays set.
- R7: `irq_out` is registered. It equals the OR over all lines of (status AND mask) from the previous cycle.
- R8: Bit 0 at byte address 0x24 enables the non-maskable path, and writing 0 to it disables that path. `nmi_out` is registered. It is high when the path was enabled and line 0's status bit was set in the previous cycle, whatever the mask is.
- R9: Register bits at and above NUM_LINES read 0 and ignore writes. Writing all ones to 0x14 and reading the value back gives a contiguous low-order mask NUM_LINES bits wide.
- R10: A pin transition reaches the status register through a two-stage synchroniser. Edge detection compares the synchronised value with its previous sample, so an edge is latched once and does not fire again while the pin stays steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_LINES | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after `rd_en` |
| irq_out | output | 1 | Combined maskable interrupt request |
| nmi_out | output | 1 | Non-maskable interrupt from line 0 |

## Verification
Corruption of a mask or sense-mode bit shows up at the register read port as soon as that register is read. It also shows up at `irq_out` one cycle after a status bit on that line is set. A fault in a synchroniser or detector stage shows up a few cycles after a pin transition, either as a missing status bit or as a spurious one. A status bit that fails to re-latch, or that re-fires after an edge has been cleared, shows up on the next status read. The bench drives every line of a four-line build through all four sense modes. It checks status, acknowledge, masking and the NMI route after each transition.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int BUS_W = 32;
  localparam logic [7:0] OFS_MASK_SET = 8'h00;
  localparam logic [7:0] OFS_MASK_CLR = 8'h04;
  localparam logic [7:0] OFS_MASK_RD  = 8'h08;
  localparam logic [7:0] OFS_STATUS   = 8'h0C;
  localparam logic [7:0] OFS_ACK      = 8'h10;
  localparam logic [7:0] OFS_SENSE    = 8'h14;
  localparam logic [7:0] OFS_EDGE_POL = 8'h18;
  localparam logic [7:0] OFS_LVL_POL  = 8'h1C;
  localparam logic [7:0] OFS_NMI_CTL  = 8'h24;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out,
  output logic [WIDTH-1:0] prev_out
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_out = sync_q;
  assign prev_out = prev_q;

  // R10: the previous-sample stage trails the synchronised value by one cycle
  a_r10_prev_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> prev_q == $past(sync_q));
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] prev,
  input  logic [WIDTH-1:0] level_mode,
  input  logic [WIDTH-1:0] rise_sel,
  input  logic [WIDTH-1:0] high_sel,
  output logic [WIDTH-1:0] event_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic edge_hit;
    logic level_hit;
    assign edge_hit  = rise_sel[g] ? (cur[g] & ~prev[g]) : (~cur[g] & prev[g]);
    assign level_hit = (cur[g] == high_sel[g]);
    assign event_o[g] = level_mode[g] ? level_hit : edge_hit;
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import eirq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pin_in,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [BUS_W-1:0]     wdata,
  output logic [BUS_W-1:0]     rdata,
  output logic                 irq_out,
  output logic                 nmi_out
);
  localparam int N = NUM_LINES;

  logic [N-1:0] pin_now, pin_prev, event_vec;
  logic [N-1:0] mask_q, status_q, sense_q, edgepol_q, lvlpol_q;
  logic         nmi_en_q;
  logic [N-1:0] wbits;
  logic [N-1:0] status_d;
  logic [N-1:0] ack_bits;
  logic [N-1:0] rd_sel;
  logic [BUS_W-1:0] rd_ext;

  eirq_sync #(.WIDTH(N)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pin_now),
    .prev_out (pin_prev)
  );

  eirq_detect #(.WIDTH(N)) u_detect (
    .cur        (pin_now),
    .prev       (pin_prev),
    .level_mode (sense_q),
    .rise_sel   (edgepol_q),
    .high_sel   (lvlpol_q),
    .event_o    (event_vec)
  );

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wbits    = wdata[N-1:0];
  assign ack_bits = (wr_en && hit(addr, OFS_ACK)) ? wbits : '0;
  assign status_d = (status_q & ~ack_bits) | event_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      status_q  <= '0;
      sense_q   <= '0;
      edgepol_q <= '0;
      lvlpol_q  <= '0;
      nmi_en_q  <= 1'b0;
      irq_out   <= 1'b0;
      nmi_out   <= 1'b0;
    end else begin
      status_q <= status_d;
      irq_out  <= |(status_q & mask_q);
      nmi_out  <= nmi_en_q & status_q[0];
      if (wr_en) begin
        if (hit(addr, OFS_MASK_SET)) mask_q    <= mask_q | wbits;
        if (hit(addr, OFS_MASK_CLR)) mask_q    <= mask_q & ~wbits;
        if (hit(addr, OFS_SENSE))    sense_q   <= wbits;
        if (hit(addr, OFS_EDGE_POL)) edgepol_q <= wbits;
        if (hit(addr, OFS_LVL_POL))  lvlpol_q  <= wbits;
        if (hit(addr, OFS_NMI_CTL))  nmi_en_q  <= wdata[0];
      end
    end
  end

  always_comb begin
    rd_sel = '0;
    if (hit(addr, OFS_MASK_RD))  rd_sel = mask_q;
    if (hit(addr, OFS_STATUS))   rd_sel = status_q;
    if (hit(addr, OFS_SENSE))    rd_sel = sense_q;
    if (hit(addr, OFS_EDGE_POL)) rd_sel = edgepol_q;
    if (hit(addr, OFS_LVL_POL))  rd_sel = lvlpol_q;
    if (hit(addr, OFS_NMI_CTL))  rd_sel = N'(nmi_en_q);
    rd_ext = '0;
    rd_ext[N-1:0] = rd_sel;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= rd_ext;
  end

  // R2: ones written to the set address appear in the mask
  a_r2_mask_set: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(addr) == ADDR_W'(OFS_MASK_SET) && !$past(rst)) |->
      ((mask_q & $past(wbits)) == $past(wbits)));
  // R2: ones written to the clear address vanish from the mask
  a_r2_mask_clr: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en) && $past(addr) == ADDR_W'(OFS_MASK_CLR) && !$past(rst)) |->
      ((mask_q & $past(wbits)) == '0));
  // R6: a detected event always leaves its status bit set
  a_r6_event_wins: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status_q & $past(event_vec)) == $past(event_vec)));
  // R7: request follows gated status by one cycle
  a_r7_irq_follow: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_out == $past(|(status_q & mask_q)));
  // R8: no NMI without the enable bit
  a_r8_nmi_gated: assert property (@(posedge clk) disable iff (rst)
    nmi_out |-> $past(nmi_en_q) && $past(status_q[0]));
endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  localparam int N = 4;
  localparam logic [31:0] IMPL = (32'd1 << N) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] pin_in = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq_out, nmi_out;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  ext_irq_ctrl #(.NUM_LINES(N), .ADDR_W(8)) u_dut (
    .clk(clk), .rst(rst), .pin_in(pin_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .nmi_out(nmi_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3); rst = 1'b0; idle(1);
    // R1 reset state
    rd(8'h08, v); chk("R1 mask", v, 0);
    rd(8'h0C, v); chk("R1 status", v, 0);
    rd(8'h14, v); chk("R1 sense", v, 0);
    rd(8'h18, v); chk("R1 edge", v, 0);
    rd(8'h1C, v); chk("R1 level", v, 0);
    rd(8'h24, v); chk("R1 nmi", v, 0);
    chk("R1 irq", {31'b0, irq_out}, 0);
    chk("R1 nmi_out", {31'b0, nmi_out}, 0);

    // R9 implemented-line discovery and ignored upper bits
    wr(8'h14, 32'hFFFF_FFFF); rd(8'h14, v); chk("R9 sense probe", v, IMPL);
    wr(8'h14, 0);
    wr(8'h00, 32'hFFFF_FFF0); rd(8'h08, v); chk("R9 mask upper", v, 0);

    // R2 set/clear mask with zero bits ignored
    wr(8'h00, 32'h5); rd(8'h08, v); chk("R2 set", v, 32'h5);
    wr(8'h04, 32'h0); rd(8'h08, v); chk("R2 zero clr", v, 32'h5);
    wr(8'h04, 32'h1); rd(8'h08, v); chk("R2 clr", v, 32'h4);
    wr(8'h04, 32'hF);

    // R4 R5 R3 R7 R10 sweep over lines and modes
    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 4; m++) begin
        // m: 0 falling, 1 rising, 2 level low, 3 level high
        logic act_lvl;
        logic is_lvl;
        logic [31:0] bit_i;
        bit_i = 32'd1 << i;
        is_lvl = (m >= 2);
        act_lvl = (m == 1) || (m == 3);
        pin_in[i] = ~act_lvl; idle(5);
        wr(8'h14, is_lvl ? bit_i : 0);
        wr(8'h18, (m == 1) ? bit_i : 0);
        wr(8'h1C, (m == 3) ? bit_i : 0);
        rd(8'h14, v); chk("R4 sense rb", v, is_lvl ? bit_i : 0);
        wr(8'h10, IMPL); idle(1);
        rd(8'h0C, v); chk("R10 idle status", v, 0);
        pin_in[i] = act_lvl; idle(5);
        rd(8'h0C, v); chk("R4 event latched", v, bit_i);
        chk("R7 masked irq", {31'b0, irq_out}, 0);
        wr(8'h00, bit_i); idle(2);
        chk("R7 unmasked irq", {31'b0, irq_out}, 1);
        wr(8'h04, bit_i); idle(2);
        chk("R7 remasked irq", {31'b0, irq_out}, 0);
        wr(8'h10, bit_i); idle(2);
        rd(8'h0C, v);
        if (is_lvl) chk("R5 R6 level persists", v, bit_i);
        else        chk("R3 R10 edge cleared once", v, 0);
        pin_in[i] = 1'b0; idle(5);
        wr(8'h14, 0); wr(8'h18, 0); wr(8'h1C, 0);
        wr(8'h10, IMPL); idle(2);
      end
    end

    // R3 clear only selected bits
    pin_in = 4'b1010; idle(5); pin_in = 4'b0000; idle(5);
    rd(8'h0C, v); chk("R3 two set", v, 32'hA);
    wr(8'h10, 32'h2); rd(8'h0C, v); chk("R3 partial clr", v, 32'h8);
    wr(8'h10, IMPL);

    // R8 NMI route on line 0, mask off
    wr(8'h24, 1); rd(8'h24, v); chk("R8 ctl rb", v, 1);
    pin_in[0] = 1'b1; idle(5); pin_in[0] = 1'b0; idle(6);
    chk("R8 nmi high", {31'b0, nmi_out}, 1);
    chk("R8 irq masked", {31'b0, irq_out}, 0);
    wr(8'h24, 0); idle(2);
    chk("R8 nmi disabled", {31'b0, nmi_out}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule